// File: doc/BRIEF.md
# SRAM Sleep Sequencer

This block sequences the low-power state of a synchronous SRAM. A sleep request arrives asynchronously to the clock. It is passed through a flip-flop synchronizer and drives a four-state machine: awake, entering, asleep and recovering. The entering and recovering states are each held for a fixed number of clock cycles. The machine closes an access gate that the surrounding array logic uses to block reads and writes. It also raises a power-down indication while the array is asleep. The array itself is not part of this block, and this block never touches its contents.

The sequencer also enforces the bus rules around sleep. If an access is still pending when entry is decided, that access is cancelled with a one-cycle pulse. Chip selects must stay inactive at the entry decision, during entry, during sleep and during the recovery window. Any active select at those times raises a one-cycle protocol-error pulse.

Top module: `sram_sleep_ctrl`

## Requirements
- R1: While reset is held and on the first cycle after it, `acc_open` is 1 and `pwr_dn`, `acc_cancel` and `sel_err` are 0.
- R2: The request crosses a two-stage synchronizer. When `sleep_req` is driven high between clock edges, `acc_open` is still 1 after the second following rising edge and becomes 0 after the third.
- R3: `pwr_dn` rises exactly ENTRY_CYC (default 2) rising edges after `acc_open` falls.
- R4: `pwr_dn` is 1 only while asleep, and `acc_open` is 0 whenever `pwr_dn` is 1 and throughout entry and recovery.
- R5: When `sleep_req` goes low between edges while asleep, `pwr_dn` falls after the third following edge, which starts recovery. `acc_open` returns to 1 exactly EXIT_CYC (default 2) edges after that.
- R6: If `acc_pend` is 1 on the edge that decides entry, `acc_cancel` is 1 for exactly the one cycle after that edge. If `acc_pend` is 0 on that edge, `acc_cancel` stays 0.
- R7: `sel_err` pulses for the cycle after any edge on which some bit of `sel_act` is 1 and the block is entering, asleep, recovering, or deciding entry. While awake with no request, active selects raise no error.
- R8: If the request is withdrawn during entry, entry still completes: `pwr_dn` rises on schedule and recovery then follows.
- R9: If the request returns during recovery, recovery finishes and `acc_open` is 1 for at least one cycle before a new entry closes it again.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_req | input | 1 | Sleep request, asynchronous to clk, active high |
| sel_act | input | NUM_SEL | Chip selects, 1 = selected |
| acc_pend | input | 1 | An array access is in flight |
| acc_open | output | 1 | 1 = array accesses allowed |
| pwr_dn | output | 1 | 1 = array is in sleep |
| acc_cancel | output | 1 | One-cycle pulse: the pending access is dropped |
| sel_err | output | 1 | One-cycle pulse: a select was active when it must not be |

## Verification
Each result has a fixed latency counted from the stimulus edge. `acc_open` falls three edges after the request is raised, because two synchronizer flops and the state register lie in the path. `pwr_dn` follows ENTRY_CYC edges later. On exit, `pwr_dn` falls three edges after the request drops, and `acc_open` returns EXIT_CYC edges after that. `acc_cancel` and `sel_err` are registered, so each appears one edge after the condition is sampled. The bench drives and samples 2 ns after every rising edge and counts edges from the drive point. Each check is placed on the exact edge where a value must change and on the edge before it.

// File: rtl/slp_pkg.sv
package slp_pkg;
    typedef enum logic [1:0] {
        SLP_AWAKE   = 2'd0,
        SLP_ENTER   = 2'd1,
        SLP_ASLEEP  = 2'd2,
        SLP_RECOVER = 2'd3
    } slp_state_e;
endpackage

// File: rtl/slp_sync.sv
module slp_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_q;
    logic [STAGES-1:0] chain_d;

    generate
        if (STAGES == 1) begin : g_one
            always_comb chain_d = din;
        end else begin : g_many
            always_comb chain_d = {chain_q[STAGES-2:0], din};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/slp_fsm.sv
module slp_fsm
    import slp_pkg::*;
#(
    parameter int ENTRY_CYC = 2,
    parameter int EXIT_CYC  = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_s,
    input  logic       acc_pend,
    output slp_state_e state,
    output logic       enter_now,
    output logic       acc_cancel
);
    localparam int MAXC = (ENTRY_CYC > EXIT_CYC) ? ENTRY_CYC : EXIT_CYC;
    localparam int CW   = (MAXC > 1) ? $clog2(MAXC) : 1;
    localparam logic [CW-1:0] ENTRY_LD = CW'(ENTRY_CYC - 1);
    localparam logic [CW-1:0] EXIT_LD  = CW'(EXIT_CYC - 1);

    typedef struct packed {
        slp_state_e    st;
        logic [CW-1:0] cnt;
        logic          cancel;
    } fsm_t;

    fsm_t r_q, r_d;

    always_comb begin
        r_d        = r_q;
        r_d.cancel = 1'b0;
        enter_now  = 1'b0;
        case (r_q.st)
            SLP_AWAKE: begin
                if (req_s) begin
                    enter_now  = 1'b1;
                    r_d.st     = SLP_ENTER;
                    r_d.cnt    = ENTRY_LD;
                    r_d.cancel = acc_pend;
                end
            end
            SLP_ENTER: begin
                if (r_q.cnt == '0) r_d.st  = SLP_ASLEEP;
                else               r_d.cnt = r_q.cnt - 1'b1;
            end
            SLP_ASLEEP: begin
                if (!req_s) begin
                    r_d.st  = SLP_RECOVER;
                    r_d.cnt = EXIT_LD;
                end
            end
            default: begin
                if (r_q.cnt == '0) r_d.st  = SLP_AWAKE;
                else               r_d.cnt = r_q.cnt - 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{st: SLP_AWAKE, cnt: '0, cancel: 1'b0};
        else        r_q <= r_d;
    end

    assign state      = r_q.st;
    assign acc_cancel = r_q.cancel;

    AST_ASLEEP_AFTER_ENTER: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == SLP_ASLEEP && $past(r_q.st) != SLP_ASLEEP) |-> $past(r_q.st) == SLP_ENTER) // R3
        else $error("asleep reached without entry");
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.cnt <= CW'(MAXC - 1))) // R3
        else $error("counter out of range");
    AST_AWAKE_AFTER_RECOVER: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == SLP_AWAKE && $past(r_q.st) != SLP_AWAKE) |-> $past(r_q.st) == SLP_RECOVER) // R5
        else $error("awake reached without recovery");
    AST_CANCEL_ON_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        acc_cancel |-> ($past(r_q.st) == SLP_AWAKE && r_q.st == SLP_ENTER)) // R6
        else $error("cancel outside entry decision");
endmodule

// File: rtl/slp_sel_mon.sv
module slp_sel_mon
    import slp_pkg::*;
#(
    parameter int NUM_SEL = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  slp_state_e         state,
    input  logic               enter_now,
    input  logic [NUM_SEL-1:0] sel_act,
    output logic               sel_err
);
    typedef struct packed {
        logic err;
    } mon_t;

    mon_t m_q, m_d;
    logic guarded;

    always_comb begin
        guarded  = (state != SLP_AWAKE) || enter_now;
        m_d.err  = guarded && (|sel_act);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) m_q <= '{err: 1'b0};
        else        m_q <= m_d;
    end

    assign sel_err = m_q.err;

    AST_ERR_NEEDS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        sel_err |-> $past(|sel_act)) // R7
        else $error("error without select");
    AST_NO_ERR_AWAKE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == SLP_AWAKE && !$past(enter_now)) |-> !sel_err) // R7
        else $error("error while idle awake");
endmodule

// File: rtl/sram_sleep_ctrl.sv
module sram_sleep_ctrl
    import slp_pkg::*;
#(
    parameter int NUM_SEL     = 3,
    parameter int SYNC_STAGES = 2,
    parameter int ENTRY_CYC   = 2,
    parameter int EXIT_CYC    = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sleep_req,
    input  logic [NUM_SEL-1:0] sel_act,
    input  logic               acc_pend,
    output logic               acc_open,
    output logic               pwr_dn,
    output logic               acc_cancel,
    output logic               sel_err
);
    logic       req_s;
    logic       enter_now;
    slp_state_e state;

    slp_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (sleep_req),
        .dout (req_s)
    );

    slp_fsm #(.ENTRY_CYC(ENTRY_CYC), .EXIT_CYC(EXIT_CYC)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_s     (req_s),
        .acc_pend  (acc_pend),
        .state     (state),
        .enter_now (enter_now),
        .acc_cancel(acc_cancel)
    );

    slp_sel_mon #(.NUM_SEL(NUM_SEL)) u_mon (
        .clk      (clk),
        .rst_n    (rst_n),
        .state    (state),
        .enter_now(enter_now),
        .sel_act  (sel_act),
        .sel_err  (sel_err)
    );

    assign acc_open = (state == SLP_AWAKE);
    assign pwr_dn   = (state == SLP_ASLEEP);

    AST_PD_GATE_SHUT: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_dn |-> !acc_open) // R4
        else $error("gate open while powered down");
    AST_OPEN_NOT_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(acc_open) |-> !pwr_dn) // R3
        else $error("power down without entry phase");
endmodule

// File: tb/sim_sram_sleep_ctrl.sv
`timescale 1ns/1ps
module sim_sram_sleep_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sleep_req = 1'b0;
    logic [2:0] sel_act = 3'b000;
    logic       acc_pend = 1'b0;
    logic       acc_open, pwr_dn, acc_cancel, sel_err;
    int         n_chk = 0;
    int         n_bad = 0;

    always #4 clk = ~clk;

    sram_sleep_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .sel_act(sel_act),
        .acc_pend(acc_pend), .acc_open(acc_open), .pwr_dn(pwr_dn),
        .acc_cancel(acc_cancel), .sel_err(sel_err)
    );

    task automatic step(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #2;
        end
    endtask

    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic back_awake();
        sleep_req = 1'b0;
        sel_act   = 3'b000;
        step(8);
        chk("R5 back awake", acc_open, 1'b1);
    endtask

    task automatic t_reset();
        chk("R1 open in reset", acc_open, 1'b1);
        chk("R1 pd in reset", pwr_dn, 1'b0);
        rst_n = 1'b1;
        step(1);
        chk("R1 open", acc_open, 1'b1);
        chk("R1 pd", pwr_dn, 1'b0);
        chk("R1 cancel", acc_cancel, 1'b0);
        chk("R1 err", sel_err, 1'b0);
    endtask

    task automatic t_cycle_pending();
        acc_pend  = 1'b1;
        sleep_req = 1'b1;
        step(2);
        chk("R2 open after 2 edges", acc_open, 1'b1);
        step(1);
        chk("R2 closed after 3 edges", acc_open, 1'b0);
        chk("R6 cancel pulse", acc_cancel, 1'b1);
        chk("R3 pd not yet", pwr_dn, 1'b0);
        acc_pend = 1'b0;
        step(1);
        chk("R6 cancel one cycle", acc_cancel, 1'b0);
        chk("R3 pd one edge before", pwr_dn, 1'b0);
        chk("R4 gate shut entering", acc_open, 1'b0);
        step(1);
        chk("R3 pd rises", pwr_dn, 1'b1);
        step(3);
        chk("R4 pd held", pwr_dn, 1'b1);
        chk("R4 gate shut asleep", acc_open, 1'b0);
        chk("R7 no err idle selects", sel_err, 1'b0);
        sleep_req = 1'b0;
        step(2);
        chk("R5 pd still high", pwr_dn, 1'b1);
        step(1);
        chk("R5 pd falls", pwr_dn, 1'b0);
        chk("R4 gate shut recovering", acc_open, 1'b0);
        step(1);
        chk("R5 gate shut one edge before", acc_open, 1'b0);
        step(1);
        chk("R5 gate reopens", acc_open, 1'b1);
    endtask

    task automatic t_sel_errors();
        sel_act = 3'b101;
        step(3);
        chk("R7 awake selects no err", sel_err, 1'b0);
        chk("R7 awake gate open", acc_open, 1'b1);
        sel_act   = 3'b000;
        sleep_req = 1'b1;
        step(3);
        chk("R6 no cancel when idle", acc_cancel, 1'b0);
        sel_act = 3'b010;
        step(1);
        chk("R7 err during entry", sel_err, 1'b1);
        sel_act = 3'b000;
        step(1);
        chk("R7 err clears", sel_err, 1'b0);
        step(2);
        sleep_req = 1'b0;
        step(3);
        sel_act = 3'b100;
        step(1);
        chk("R7 err during recovery", sel_err, 1'b1);
        back_awake();
    endtask

    task automatic t_withdraw();
        sleep_req = 1'b1;
        step(3);
        chk("R8 gate closed", acc_open, 1'b0);
        sleep_req = 1'b0;
        step(2);
        chk("R8 entry completes", pwr_dn, 1'b1);
        step(1);
        chk("R8 recovery starts", pwr_dn, 1'b0);
        step(1);
        chk("R8 gate still shut", acc_open, 1'b0);
        step(1);
        chk("R8 gate reopens", acc_open, 1'b1);
    endtask

    task automatic t_rerequest();
        sleep_req = 1'b1;
        step(6);
        chk("R9 asleep", pwr_dn, 1'b1);
        sleep_req = 1'b0;
        step(3);
        chk("R9 recovering", pwr_dn, 1'b0);
        sleep_req = 1'b1;
        step(2);
        chk("R9 gate open between", acc_open, 1'b1);
        step(1);
        chk("R9 new entry closes gate", acc_open, 1'b0);
        step(2);
        chk("R9 asleep again", pwr_dn, 1'b1);
        back_awake();
    endtask

    initial begin : watchdog
        #200000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        step(2);
        t_reset();
        t_cycle_pending();
        step(2);
        t_sel_errors();
        t_withdraw();
        step(2);
        t_rerequest();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule